// File: doc/BRIEF.md
# Accumulator ALU with Bit-Mask Operands

This block is the arithmetic and logic datapath of a small 8-bit accumulator-style controller. It has no clock. Within one cycle it picks an A operand and a B operand from a few sources, applies one of nine operations, and returns the result with a zero flag and a carry flag. The surrounding core writes the result back, stores the flags and handles the skip behaviour. All of that lies outside this block.

The A operand can come from the working register, the file-read bus, the instruction literal, or a generated bit mask. The bit mask is one-hot at a 3-bit index, and a polarity input can invert it. A bit set is OR of the plain mask with the file value. A bit clear is AND of the inverted mask with the file value. The B operand can come from the working register, the file bus, the literal, or the constant one. So increment is ADD with B=1, and decrement is SUB with B=1.

Top module: `acc_alu`

## Requirements
- R1: The A operand select `a_sel` picks 0=working register, 1=file bus, 2=literal, 3=bit mask.
- R2: The B operand select `b_sel` picks 0=working register, 1=file bus, 2=literal, 3=constant 0x01.
- R3: With `mask_inv`=0 the bit mask has exactly one bit set, at position `bit_idx`. With `mask_inv`=1 every bit is inverted. AND with the inverted mask clears one bit, and OR with the plain mask sets one bit.
- R4: Opcode 0000 (ADD) returns A+B modulo 256. `carry_out` is the ninth bit of the sum.
- R5: Opcode 1000 (SUB) returns A-B modulo 256. `carry_out` is 1 exactly when A >= B (unsigned), meaning no borrow.
- R6: Opcodes 0001, 0010 and 0011 return A AND B, A OR B and A XOR B.
- R7: Opcode 0100 returns the ones complement of A. Opcode 0111 returns A with its upper and lower nibbles exchanged.
- R8: Opcode 0101 rotates right through carry: the result is {carry_in, A[7:1]} and `carry_out` is A[0]. Opcode 0110 rotates left through carry: the result is {A[6:0], carry_in} and `carry_out` is A[7].
- R9: For opcodes 0001, 0010, 0011, 0100, 0111 and every unused opcode, `carry_out` equals `carry_in`.
- R10: Unused opcodes (1001 to 1111) return a result of 0x00.
- R11: `zero` is 1 exactly when the 8-bit result is 0x00, for every opcode.
- R12: With A taken from the file bus and B set to the constant one, ADD increments (0xFF wraps to 0x00 with carry 1) and SUB decrements (0x00 wraps to 0xFF with carry 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w_reg | input | 8 | Working register value |
| file_bus | input | 8 | File register read data |
| literal | input | 8 | Instruction literal |
| bit_idx | input | 3 | Bit position for the mask |
| mask_inv | input | 1 | 1 inverts the bit mask |
| a_sel | input | 2 | A operand source select |
| b_sel | input | 2 | B operand source select |
| op | input | 4 | Operation code |
| carry_in | input | 1 | Stored carry flag |
| result | output | 8 | Operation result |
| zero | output | 1 | Result-is-zero flag |
| carry_out | output | 1 | New carry flag |

## Verification
Some properties are checked each time the inputs settle:
- the mask's population count (one bit set, or seven when inverted);
- the no-borrow carry of SUB against an unsigned comparison;
- the carry bit that enters each rotate and the bit that leaves it;
- carry passing unchanged through the logical, complement, swap and unused opcodes;
- the zero result on unused opcodes;
- the zero flag against the result.

Only the bench's directed scenarios show the following:
- that each select code routes the intended source;
- the arithmetic values themselves;
- the nibble swap;
- the wrap of increment and decrement at 0xFF and 0x00.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'b0000,
        OP_AND  = 4'b0001,
        OP_OR   = 4'b0010,
        OP_XOR  = 4'b0011,
        OP_COM  = 4'b0100,
        OP_ROR  = 4'b0101,
        OP_ROL  = 4'b0110,
        OP_SWAP = 4'b0111,
        OP_SUB  = 4'b1000
    } alu_op_e;

    typedef enum logic [1:0] {
        ASRC_WREG = 2'b00,
        ASRC_FILE = 2'b01,
        ASRC_LIT  = 2'b10,
        ASRC_MASK = 2'b11
    } a_src_e;

    typedef enum logic [1:0] {
        BSRC_WREG = 2'b00,
        BSRC_FILE = 2'b01,
        BSRC_LIT  = 2'b10,
        BSRC_ONE  = 2'b11
    } b_src_e;

endpackage

// File: rtl/bit_mask_gen.sv
module bit_mask_gen #(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             invert,
    output logic [WIDTH-1:0] mask
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign mask[i] = (idx == IDX_W'(i)) ^ invert;
    end

    always_comb begin
        // R3
        if (!invert) begin
            mask_onehot_chk: assert ($countones(mask) == 1)
                else $error("mask not one-hot");
        end else begin
            mask_inverted_chk: assert ($countones(mask) == WIDTH - 1)
                else $error("inverted mask wrong population");
        end
    end
endmodule

// File: rtl/operand_mux.sv
module operand_mux #(
    parameter int WIDTH = 8,
    parameter int NSRC  = 4,
    localparam int SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0][WIDTH-1:0] src,
    input  logic [SEL_W-1:0]           sel,
    output logic [WIDTH-1:0]           out
);
    always_comb begin
        out = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (sel == SEL_W'(k)) out = src[k];
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int HALF = WIDTH / 2
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             c;
    } alu_out_t;

    alu_out_t    out_d;
    logic [WIDTH:0] sum_d;
    logic [WIDTH:0] diff_d;
    alu_op_e     op_e;

    assign op_e = alu_op_e'(op);

    always_comb begin
        sum_d     = {1'b0, a} + {1'b0, b};
        diff_d    = {1'b0, a} - {1'b0, b};
        out_d.res = '0;
        out_d.c   = cin;
        case (op_e)
            OP_ADD:  begin out_d.res = sum_d[WIDTH-1:0];  out_d.c = sum_d[WIDTH];   end
            OP_SUB:  begin out_d.res = diff_d[WIDTH-1:0]; out_d.c = ~diff_d[WIDTH]; end
            OP_AND:  out_d.res = a & b;
            OP_OR:   out_d.res = a | b;
            OP_XOR:  out_d.res = a ^ b;
            OP_COM:  out_d.res = ~a;
            OP_ROR:  begin out_d.res = {cin, a[WIDTH-1:1]}; out_d.c = a[0];       end
            OP_ROL:  begin out_d.res = {a[WIDTH-2:0], cin}; out_d.c = a[WIDTH-1]; end
            OP_SWAP: out_d.res = {a[HALF-1:0], a[WIDTH-1:HALF]};
            default: out_d.res = '0;
        endcase
    end

    assign res  = out_d.res;
    assign cout = out_d.c;

    always_comb begin
        // R5
        if (op == 4'b1000) begin
            sub_borrow_chk: assert (cout == (a >= b))
                else $error("SUB carry disagrees with compare");
        end
        // R8
        if (op == 4'b0101) begin
            ror_ends_chk: assert (res[WIDTH-1] == cin && cout == a[0])
                else $error("ROR carry path wrong");
        end
        // R8
        if (op == 4'b0110) begin
            rol_ends_chk: assert (res[0] == cin && cout == a[WIDTH-1])
                else $error("ROL carry path wrong");
        end
        // R9
        if (op != 4'b0000 && op != 4'b1000 && op != 4'b0101 && op != 4'b0110) begin
            carry_hold_chk: assert (cout == cin)
                else $error("carry not passed through");
        end
        // R10
        if (op[3] && op[2:0] != 3'b000) begin
            unused_zero_chk: assert (res == '0)
                else $error("unused opcode result nonzero");
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] w_reg,
    input  logic [WIDTH-1:0] file_bus,
    input  logic [WIDTH-1:0] literal,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             mask_inv,
    input  logic [1:0]       a_sel,
    input  logic [1:0]       b_sel,
    input  logic [3:0]       op,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out
);
    logic [WIDTH-1:0]      mask_d;
    logic [WIDTH-1:0]      opa_d;
    logic [WIDTH-1:0]      opb_d;
    logic [3:0][WIDTH-1:0] a_srcs_d;
    logic [3:0][WIDTH-1:0] b_srcs_d;

    bit_mask_gen #(.WIDTH(WIDTH)) u_mask (
        .idx    (bit_idx),
        .invert (mask_inv),
        .mask   (mask_d)
    );

    always_comb begin
        a_srcs_d[ASRC_WREG] = w_reg;
        a_srcs_d[ASRC_FILE] = file_bus;
        a_srcs_d[ASRC_LIT]  = literal;
        a_srcs_d[ASRC_MASK] = mask_d;
        b_srcs_d[BSRC_WREG] = w_reg;
        b_srcs_d[BSRC_FILE] = file_bus;
        b_srcs_d[BSRC_LIT]  = literal;
        b_srcs_d[BSRC_ONE]  = WIDTH'(1);
    end

    operand_mux #(.WIDTH(WIDTH), .NSRC(4)) u_amux (
        .src (a_srcs_d),
        .sel (a_sel),
        .out (opa_d)
    );

    operand_mux #(.WIDTH(WIDTH), .NSRC(4)) u_bmux (
        .src (b_srcs_d),
        .sel (b_sel),
        .out (opb_d)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .a    (opa_d),
        .b    (opb_d),
        .op   (op),
        .cin  (carry_in),
        .res  (result),
        .cout (carry_out)
    );

    assign zero = ~|result;

    always_comb begin
        // R1
        if (a_sel == 2'b01) begin
            a_file_route_chk: assert (opa_d == file_bus)
                else $error("A operand not file bus");
        end
        // R2
        if (b_sel == 2'b11) begin
            b_one_route_chk: assert (opb_d == WIDTH'(1))
                else $error("B operand not one");
        end
        // R11
        zero_flag_chk: assert (zero == (result == '0))
            else $error("zero flag mismatch");
    end
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    logic       clk = 1'b0;
    logic [7:0] w_reg, file_bus, literal;
    logic [2:0] bit_idx;
    logic       mask_inv;
    logic [1:0] a_sel, b_sel;
    logic [3:0] op;
    logic       carry_in;
    logic [7:0] result;
    logic       zero, carry_out;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    acc_alu u_dut (
        .w_reg(w_reg), .file_bus(file_bus), .literal(literal),
        .bit_idx(bit_idx), .mask_inv(mask_inv), .a_sel(a_sel), .b_sel(b_sel),
        .op(op), .carry_in(carry_in), .result(result), .zero(zero),
        .carry_out(carry_out)
    );

    task automatic apply(input logic [1:0] as, input logic [1:0] bs, input logic [3:0] o,
                         input logic [7:0] w, input logic [7:0] f, input logic [7:0] l,
                         input logic [2:0] idx, input logic inv, input logic c);
        @(negedge clk);
        a_sel = as; b_sel = bs; op = o; w_reg = w; file_bus = f; literal = l;
        bit_idx = idx; mask_inv = inv; carry_in = c;
        #1;
    endtask

    task automatic expect_out(input string req, input logic [7:0] er, input logic ez,
                              input logic ec);
        checks++;
        if (result !== er || zero !== ez || carry_out !== ec) begin
            errors++;
            $display("FAIL %s: got r=%02h z=%0b c=%0b, expected r=%02h z=%0b c=%0b",
                     req, result, zero, carry_out, er, ez, ec);
        end
    endtask

    // R1: COM exposes A as ~A
    task automatic t_a_select();
        apply(2'd0, 2'd0, 4'b0100, 8'h11, 8'h22, 8'h33, 3'd2, 1'b0, 1'b0);
        expect_out("R1 wreg", 8'hEE, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b0100, 8'h11, 8'h22, 8'h33, 3'd2, 1'b0, 1'b0);
        expect_out("R1 file", 8'hDD, 1'b0, 1'b0);
        apply(2'd2, 2'd0, 4'b0100, 8'h11, 8'h22, 8'h33, 3'd2, 1'b0, 1'b0);
        expect_out("R1 literal", 8'hCC, 1'b0, 1'b0);
        apply(2'd3, 2'd0, 4'b0100, 8'h11, 8'h22, 8'h33, 3'd2, 1'b0, 1'b0);
        expect_out("R1 mask", 8'hFB, 1'b0, 1'b0);
    endtask

    // R2: ADD with A = literal 0 exposes B
    task automatic t_b_select();
        apply(2'd2, 2'd0, 4'b0000, 8'h11, 8'h22, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R2 wreg", 8'h11, 1'b0, 1'b0);
        apply(2'd2, 2'd1, 4'b0000, 8'h11, 8'h22, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R2 file", 8'h22, 1'b0, 1'b0);
        apply(2'd2, 2'd2, 4'b0000, 8'h11, 8'h22, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R2 literal", 8'h00, 1'b1, 1'b0);
        apply(2'd2, 2'd3, 4'b0000, 8'h11, 8'h22, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R2 one", 8'h01, 1'b0, 1'b0);
    endtask

    // R3: mask positions, both polarities, then bit clear and bit set
    task automatic t_mask();
        for (int i = 0; i < 8; i++) begin
            apply(2'd3, 2'd0, 4'b0010, 8'h00, 8'h00, 8'h00, 3'(i), 1'b0, 1'b1);
            expect_out("R3 plain", 8'(1 << i), 1'b0, 1'b1);
            apply(2'd3, 2'd0, 4'b0010, 8'h00, 8'h00, 8'h00, 3'(i), 1'b1, 1'b0);
            expect_out("R3 inverted", ~8'(1 << i), 1'b0, 1'b0);
        end
        apply(2'd3, 2'd1, 4'b0001, 8'h00, 8'hFF, 8'h00, 3'd5, 1'b1, 1'b0);
        expect_out("R3 bit clear", 8'hDF, 1'b0, 1'b0);
        apply(2'd3, 2'd1, 4'b0010, 8'h00, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0);
        expect_out("R3 bit set", 8'h80, 1'b0, 1'b0);
    endtask

    task automatic t_add();
        apply(2'd1, 2'd0, 4'b0000, 8'h41, 8'h3C, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R4 plain", 8'h7D, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b0000, 8'h64, 8'hC8, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R4 carry", 8'h2C, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b0000, 8'h80, 8'h80, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R4 R11 zero sum", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_sub();
        apply(2'd1, 2'd0, 4'b1000, 8'h03, 8'h05, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R5 no borrow", 8'h02, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b1000, 8'h05, 8'h03, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R5 borrow", 8'hFE, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b1000, 8'h07, 8'h07, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R5 R11 equal", 8'h00, 1'b1, 1'b1);
    endtask

    // R6 with R9 carry passthrough
    task automatic t_logic();
        apply(2'd1, 2'd0, 4'b0001, 8'h3C, 8'hF0, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R6 R9 and", 8'h30, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b0010, 8'h30, 8'h0F, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R6 R9 or", 8'h3F, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b0011, 8'hFF, 8'hAA, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R6 R9 xor", 8'h55, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b0011, 8'h5A, 8'h5A, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R6 R11 xor zero", 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_com_swap();
        apply(2'd1, 2'd0, 4'b0100, 8'h00, 8'h0F, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R7 R9 com", 8'hF0, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b0111, 8'h00, 8'hA5, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R7 R9 swap", 8'h5A, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b0100, 8'h00, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R7 R11 com zero", 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_rotate();
        apply(2'd1, 2'd0, 4'b0101, 8'h00, 8'h81, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R8 ror c0", 8'h40, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b0101, 8'h00, 8'h02, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R8 ror c1", 8'h81, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b0110, 8'h00, 8'h81, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R8 rol c0", 8'h02, 1'b0, 1'b1);
        apply(2'd1, 2'd0, 4'b0110, 8'h00, 8'h40, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R8 rol c1", 8'h81, 1'b0, 1'b0);
        apply(2'd1, 2'd0, 4'b0101, 8'h00, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R8 R11 ror zero", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_unused();
        for (int k = 9; k < 16; k++) begin
            apply(2'd1, 2'd0, 4'(k), 8'hFF, 8'hFF, 8'hFF, 3'd0, 1'b0, 1'(k & 1));
            expect_out("R10 R9 unused", 8'h00, 1'b1, 1'(k & 1));
        end
    endtask

    task automatic t_inc_dec();
        apply(2'd1, 2'd3, 4'b0000, 8'h00, 8'h41, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R12 inc", 8'h42, 1'b0, 1'b0);
        apply(2'd1, 2'd3, 4'b0000, 8'h00, 8'hFF, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R12 inc wrap", 8'h00, 1'b1, 1'b1);
        apply(2'd1, 2'd3, 4'b1000, 8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1);
        expect_out("R12 dec wrap", 8'hFF, 1'b0, 1'b0);
        apply(2'd1, 2'd3, 4'b1000, 8'h00, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0);
        expect_out("R12 dec to zero", 8'h00, 1'b1, 1'b1);
    endtask

    initial begin
        w_reg = '0; file_bus = '0; literal = '0; bit_idx = '0; mask_inv = 1'b0;
        a_sel = '0; b_sel = '0; op = '0; carry_in = 1'b0;
        repeat (2) @(negedge clk);
        t_a_select();
        t_b_select();
        t_mask();
        t_add();
        t_sub();
        t_logic();
        t_com_swap();
        t_rotate();
        t_unused();
        t_inc_dec();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule